// File: doc/BRIEF.md
# Reconfiguration Engine Control Interface

This block is the register front end that a host uses to steer a partial-reconfiguration engine. It hangs on a 64-bit memory-mapped register bus. It accepts 32-bit configuration words into an internal FIFO and hands them, one per ready cycle, to a configuration sink. The host never sees a FIFO-full flag. Instead it reads a credit count that equals the free FIFO space, and it writes a word only while more than one credit remains. The block also gathers error strobes from the engine into a sticky register that the host clears by writing ones, and it returns a fixed 128-bit interface identifier together with a feature header word.

A load runs as a short handshake sequence. The host first pulses an engine reset: it sets the reset request, waits for the acknowledge, then clears the request. It then sets the start request along with a target region and an image kind, and streams words to the data register under credit control. Finally it sets the push-complete bit and polls until the block clears the start request. That clear only happens once every queued word has gone to the sink.

The sequencer has four states. `ST_IDLE` has host status 0. `ST_RESET` has host status 1. `ST_LOAD` has host status 2. `ST_DRAIN` has host status 3. The transitions are:
- `rst_set` (a control write with bit 0 set) moves any state to `ST_RESET`.
- `rst_rel` (a control write with bit 0 clear) moves `ST_RESET` to `ST_IDLE`.
- `go` (a control write with bit 12 set) moves `ST_IDLE` to `ST_LOAD`.
- `fin` (a control write with bit 13 set) moves `ST_LOAD` to `ST_DRAIN`.
- `drained` (the FIFO is empty at a clock edge) moves `ST_DRAIN` to `ST_IDLE`.

Top module: `cfgld_front`

## Requirements
- R1: After reset the control word reads 0, the error word reads 0, host status is 0 and the credit field equals the FIFO depth `DEPTH` (at most 511).
- R2: A control write (offset 0x08) with bit 0 set sets the reset request (bit 0) and the acknowledge (bit 4). It flushes the FIFO, clears bits 12 and 13 and sets host status (status bits 27:24) to 1. A later control write with bit 0 clear clears bits 0 and 4 and returns host status to 0.
- R3: A control write with bit 12 set, made in `ST_IDLE`, sets bit 12 and latches the region (bits 9:8) and the image kind (bit 14); host status becomes 2. In any other state, bits 12, 14 and 9:8 of a control write have no effect. Bits 63:32 of every control write are stored and read back.
- R4: While loading, a write to the data register (offset 0x18) with credit above 0 enqueues the low 32 bits and ignores the upper 32 bits. The credit field (status bits 8:0) always equals `DEPTH` minus the FIFO occupancy.
- R5: A data write made while loading at zero credit is dropped and sets error bit 4.
- R6: A data write made outside `ST_LOAD` changes neither the credit nor the sink output.
- R7: Words reach the sink in write order. While `snk_ready` is low, `snk_valid` stays high and `snk_data` stays stable.
- R8: A control write with bit 13 set while loading sets bit 13 and host status 3. Bits 12 and 13 stay set until the FIFO has drained. They then clear by themselves, and host status returns to 0.
- R9: Error bits 0–3 and 6 are set by `err_src` strobes. Bit 5 never sets. The bits are sticky. A write of ones to offset 0x20 clears them, but a strobe in the same cycle wins over the clear.
- R10: Status bit 16 is 1 exactly when any error bit is set.
- R11: Status bits 22:20 report {sink stalled (`snk_valid` high, `snk_ready` low), FIFO full, FIFO empty}.
- R12: With `csr_rd` high, offsets 0x00, 0xA8 and 0xB0 return `FEAT_HDR`, `IFID_LO` and `IFID_HI`. Unmapped offsets, and any cycle with `csr_rd` low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read enable |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, combinational |
| err_src | input | 7 | Engine error strobes, one per error bit |
| snk_valid | output | 1 | Word available for the sink |
| snk_data | output | 32 | Word to the sink |
| snk_ready | input | 1 | Sink takes a word this cycle |
| region_sel | output | REGION_W | Latched target region |
| image_kind | output | 1 | Latched image kind |
| load_active | output | 1 | Start request is set |

## Verification
The bench fills the FIFO with the sink stalled and then writes once more. A design with an off-by-one in the credit or full logic would either take the extra word or miss the overflow error. It tries a second start and region change in the middle of a load, which a loose state decode would act on. It issues an engine reset with words still queued, and a design that failed to flush would keep presenting stale data. It also clears an error bit in the same cycle that a strobe sets it, and checks that `load_active` stays high during a stalled drain, so a design that ended the load early or let the clear win would show up.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESET = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DRAIN = 2'd3
    } eng_state_t;

    localparam logic [7:0] OFS_HDR  = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_DATA = 8'h18;
    localparam logic [7:0] OFS_ERR  = 8'h20;
    localparam logic [7:0] OFS_IDLO = 8'hA8;
    localparam logic [7:0] OFS_IDHI = 8'hB0;

    localparam int CB_RST    = 0;
    localparam int CB_ACK    = 4;
    localparam int CB_REGION = 8;
    localparam int CB_START  = 12;
    localparam int CB_PUSHED = 13;
    localparam int CB_KIND   = 14;

    localparam int SB_FAILED = 16;
    localparam int SB_CTRL   = 20;
    localparam int SB_HOST   = 24;

    localparam int           ERR_W    = 7;
    localparam int           ERR_OVF  = 4;
    localparam logic [6:0]   ERR_MASK = 7'h5F;

    localparam int CREDIT_W = 9;

endpackage

// File: rtl/cfgld_fifo.sv
module cfgld_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= bump(wptr);
            if (rd_en) rptr <= bump(rptr);
            case ({wr_en, rd_en})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) mem[wptr] <= wr_data;
    end

    assign rd_data = mem[rptr];
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));

    a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    a_r7_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int REGION_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic                ctl_rst,
    input  logic                ctl_start,
    input  logic                ctl_pushed,
    input  logic                ctl_kind,
    input  logic [REGION_W-1:0] ctl_region,
    input  logic                fifo_empty,
    output eng_state_t          state,
    output logic                rst_req,
    output logic                rst_ack,
    output logic                start_req,
    output logic                push_done,
    output logic [REGION_W-1:0] region,
    output logic                kind,
    output logic                flush,
    output logic                accept_data
);

    eng_state_t nxt;
    logic rst_set, rst_rel, go, fin, drained;

    assign rst_set = ctrl_wr && ctl_rst;
    assign rst_rel = ctrl_wr && !ctl_rst && (state == ST_RESET);
    assign go      = ctrl_wr && !ctl_rst && ctl_start  && (state == ST_IDLE);
    assign fin     = ctrl_wr && !ctl_rst && ctl_pushed && (state == ST_LOAD);
    assign drained = !rst_set && (state == ST_DRAIN) && fifo_empty;

    assign flush       = rst_set;
    assign accept_data = (state == ST_LOAD);

    always_comb begin
        nxt = state;
        if (rst_set) begin
            nxt = ST_RESET;
        end else begin
            unique case (state)
                ST_IDLE:  if (go)         nxt = ST_LOAD;
                ST_RESET: if (rst_rel)    nxt = ST_IDLE;
                ST_LOAD:  if (fin)        nxt = ST_DRAIN;
                ST_DRAIN: if (fifo_empty) nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req   <= 1'b0;
            rst_ack   <= 1'b0;
            start_req <= 1'b0;
            push_done <= 1'b0;
            region    <= '0;
            kind      <= 1'b0;
        end else if (rst_set) begin
            rst_req   <= 1'b1;
            rst_ack   <= 1'b1;
            start_req <= 1'b0;
            push_done <= 1'b0;
        end else begin
            if (rst_rel) begin
                rst_req <= 1'b0;
                rst_ack <= 1'b0;
            end
            if (go) begin
                start_req <= 1'b1;
                region    <= ctl_region;
                kind      <= ctl_kind;
            end
            if (fin) push_done <= 1'b1;
            if (drained) begin
                start_req <= 1'b0;
                push_done <= 1'b0;
            end
        end
    end

    a_r2_ack_only_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ack |-> (state == ST_RESET));
    a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_req) |-> ($past(state) == ST_IDLE));
    a_r8_end_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_req) && !rst_ack) |-> $past(fifo_empty));
    a_r8_pushed_within_load: assert property (@(posedge clk) disable iff (!rst_n)
        push_done |-> start_req);

endmodule

// File: rtl/cfgld_errs.sv
module cfgld_errs
    import cfgld_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] src,
    input  logic             ovf,
    input  logic             clr_wr,
    input  logic [ERR_W-1:0] clr_mask,
    output logic [ERR_W-1:0] err_q
);

    logic [ERR_W-1:0] set_v, clr_v;

    always_comb begin
        set_v = src;
        set_v[ERR_OVF] = src[ERR_OVF] | ovf;
        set_v = set_v & ERR_MASK;
        clr_v = clr_wr ? clr_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~clr_v) | set_v;
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_wr) |-> ((err_q & $past(err_q)) == $past(err_q)));
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q & $past(set_v)) == $past(set_v)));

endmodule

// File: rtl/cfgld_front.sv
module cfgld_front
    import cfgld_pkg::*;
#(
    parameter int          DEPTH    = 64,
    parameter int          REGION_W = 2,
    parameter logic [63:0] FEAT_HDR = 64'h3000_0000_0100_0005,
    parameter logic [63:0] IFID_LO  = 64'h0123_4567_89AB_CDEF,
    parameter logic [63:0] IFID_HI  = 64'hFEDC_BA98_7654_3210
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_wr,
    input  logic                csr_rd,
    input  logic [7:0]          csr_addr,
    input  logic [63:0]         csr_wdata,
    output logic [63:0]         csr_rdata,
    input  logic [6:0]          err_src,
    output logic                snk_valid,
    output logic [31:0]         snk_data,
    input  logic                snk_ready,
    output logic [REGION_W-1:0] region_sel,
    output logic                image_kind,
    output logic                load_active
);

    localparam int CNTW = $clog2(DEPTH + 1);

    logic wr_ctrl, wr_data, wr_err;
    assign wr_ctrl = csr_wr && (csr_addr == OFS_CTRL);
    assign wr_data = csr_wr && (csr_addr == OFS_DATA);
    assign wr_err  = csr_wr && (csr_addr == OFS_ERR);

    eng_state_t state;
    logic rst_req, rst_ack, start_req, push_done, kind, flush, accept;
    logic [REGION_W-1:0] region;

    cfgld_seq #(.REGION_W(REGION_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (wr_ctrl),
        .ctl_rst     (csr_wdata[CB_RST]),
        .ctl_start   (csr_wdata[CB_START]),
        .ctl_pushed  (csr_wdata[CB_PUSHED]),
        .ctl_kind    (csr_wdata[CB_KIND]),
        .ctl_region  (csr_wdata[CB_REGION +: REGION_W]),
        .fifo_empty  (fifo_empty),
        .state       (state),
        .rst_req     (rst_req),
        .rst_ack     (rst_ack),
        .start_req   (start_req),
        .push_done   (push_done),
        .region      (region),
        .kind        (kind),
        .flush       (flush),
        .accept_data (accept)
    );

    logic            fifo_wr, fifo_rd, fifo_empty, fifo_full, ovf;
    logic [CNTW-1:0] fifo_cnt;

    assign fifo_wr = wr_data && accept && !fifo_full;
    assign ovf     = wr_data && accept &&  fifo_full;
    assign fifo_rd = snk_valid && snk_ready;

    cfgld_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (fifo_wr),
        .wr_data (csr_wdata[31:0]),
        .rd_en   (fifo_rd),
        .rd_data (snk_data),
        .count   (fifo_cnt),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    assign snk_valid = !fifo_empty;

    logic [ERR_W-1:0] err_q;

    cfgld_errs u_errs (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (err_src),
        .ovf      (ovf),
        .clr_wr   (wr_err),
        .clr_mask (csr_wdata[ERR_W-1:0]),
        .err_q    (err_q)
    );

    logic [31:0] cfg_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg_q <= '0;
        else if (wr_ctrl) cfg_q <= csr_wdata[63:32];
    end

    logic [CREDIT_W-1:0] credit;
    assign credit = CREDIT_W'(DEPTH) - CREDIT_W'(fifo_cnt);

    logic [63:0] ctrl_word, stat_word;
    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[CB_RST]                = rst_req;
        ctrl_word[CB_ACK]                = rst_ack;
        ctrl_word[CB_REGION +: REGION_W] = region;
        ctrl_word[CB_START]              = start_req;
        ctrl_word[CB_PUSHED]             = push_done;
        ctrl_word[CB_KIND]               = kind;
        ctrl_word[63:32]                 = cfg_q;

        stat_word                   = '0;
        stat_word[CREDIT_W-1:0]     = credit;
        stat_word[SB_FAILED]        = |err_q;
        stat_word[SB_CTRL +: 3]     = {snk_valid & ~snk_ready, fifo_full, fifo_empty};
        stat_word[SB_HOST +: 4]     = {2'b00, state};
    end

    always_comb begin
        csr_rdata = '0;
        if (csr_rd) begin
            case (csr_addr)
                OFS_HDR:  csr_rdata = FEAT_HDR;
                OFS_CTRL: csr_rdata = ctrl_word;
                OFS_STAT: csr_rdata = stat_word;
                OFS_ERR:  csr_rdata = {{(64-ERR_W){1'b0}}, err_q};
                OFS_IDLO: csr_rdata = IFID_LO;
                OFS_IDHI: csr_rdata = IFID_HI;
                default:  csr_rdata = '0;
            endcase
        end
    end

    assign region_sel  = region;
    assign image_kind  = kind;
    assign load_active = start_req;

    a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready && !flush) |=> (snk_valid && $stable(snk_data)));
    a_r6_no_entry_outside_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD && !flush && !snk_valid) |=> !snk_valid);

endmodule

// File: tb/cfgld_front_test.sv
`timescale 1ns/1ps
module cfgld_front_test;

    localparam int          DEPTH = 8;
    localparam logic [63:0] HDR   = 64'h1111_2222_3333_0005;
    localparam logic [63:0] IDL   = 64'hAAAA_5555_0F0F_1234;
    localparam logic [63:0] IDH   = 64'h9876_FEDC_0000_4321;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0, csr_rd = 1'b0;
    logic [7:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic [6:0]  err_src = '0;
    logic        snk_valid, snk_ready = 1'b0;
    logic [31:0] snk_data;
    logic [1:0]  region_sel;
    logic        image_kind, load_active;

    always #10 clk = ~clk;

    cfgld_front #(.DEPTH(DEPTH), .REGION_W(2), .FEAT_HDR(HDR),
                  .IFID_LO(IDL), .IFID_HI(IDH)) uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .err_src(err_src), .snk_valid(snk_valid), .snk_data(snk_data),
        .snk_ready(snk_ready), .region_sel(region_sel),
        .image_kind(image_kind), .load_active(load_active)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // behavioural reference model
    int          m_state;
    bit          m_rst, m_ack, m_start, m_push, m_kind;
    logic [1:0]  m_region;
    logic [31:0] m_cfg;
    logic [6:0]  m_err;
    logic [31:0] m_q[$];

    always @(posedge clk) begin
        int sz;
        bit pop, wc, wd, we, rs, do_push;
        logic [6:0] nerr;
        if (!rst_n) begin
            m_state = 0; m_rst = 0; m_ack = 0; m_start = 0; m_push = 0;
            m_kind = 0; m_region = 0; m_cfg = 0; m_err = 0; m_q.delete();
        end else begin
            sz = m_q.size();
            pop = (sz > 0) && snk_ready;
            wc = csr_wr && csr_addr == 8'h08;
            wd = csr_wr && csr_addr == 8'h18;
            we = csr_wr && csr_addr == 8'h20;
            rs = wc && csr_wdata[0];
            nerr = err_src & 7'h5F;
            do_push = 0;
            if (wd && m_state == 2) begin
                if (sz < DEPTH) do_push = 1;
                else nerr[4] = 1'b1;
            end
            if (pop) void'(m_q.pop_front());
            if (do_push) m_q.push_back(csr_wdata[31:0]);
            m_err = (m_err & ~(we ? csr_wdata[6:0] : 7'h0)) | nerr;
            if (wc) m_cfg = csr_wdata[63:32];
            if (rs) begin
                m_q.delete();
                m_state = 1; m_rst = 1; m_ack = 1; m_start = 0; m_push = 0;
            end else begin
                case (m_state)
                    0: if (wc && csr_wdata[12]) begin
                        m_state = 2; m_start = 1;
                        m_region = csr_wdata[9:8]; m_kind = csr_wdata[14];
                    end
                    1: if (wc) begin m_state = 0; m_rst = 0; m_ack = 0; end
                    2: if (wc && csr_wdata[13]) begin m_state = 3; m_push = 1; end
                    default: if (sz == 0) begin m_state = 0; m_start = 0; m_push = 0; end
                endcase
            end
        end
    end

    function automatic logic [63:0] model_read(input logic [7:0] a);
        logic [63:0] w;
        int sz;
        sz = m_q.size();
        w = '0;
        case (a)
            8'h00: w = HDR;
            8'h08: begin
                w[0] = m_rst; w[4] = m_ack; w[9:8] = m_region;
                w[12] = m_start; w[13] = m_push; w[14] = m_kind; w[63:32] = m_cfg;
            end
            8'h10: begin
                w[8:0] = 9'(DEPTH - sz);
                w[16] = |m_err;
                w[20] = (sz == 0); w[21] = (sz == DEPTH); w[22] = (sz > 0) && !snk_ready;
                w[27:24] = 4'(m_state);
            end
            8'h20: w[6:0] = m_err;
            8'hA8: w = IDL;
            8'hB0: w = IDH;
            default: w = '0;
        endcase
        return w;
    endfunction

    logic [31:0] rx[$];
    logic [31:0] exp_w[$];

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(snk_valid == (m_q.size() > 0), "R7 sink valid", 64'(snk_valid),
                  64'(m_q.size() > 0));
            if (snk_valid && m_q.size() > 0)
                check(snk_data == m_q[0], "R7 sink data", 64'(snk_data), 64'(m_q[0]));
            if (csr_rd)
                check(csr_rdata == model_read(csr_addr), "R12 R4 R11 model read",
                      csr_rdata, model_read(csr_addr));
            else
                check(csr_rdata == 64'h0, "R12 idle read", csr_rdata, 64'h0);
            if (snk_valid && snk_ready) rx.push_back(snk_data);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", 64'(cyc), 64'h0);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        step();
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd_val(input logic [7:0] a, output logic [63:0] v);
        csr_rd = 1'b1; csr_addr = a;
        @(negedge clk);
        v = csr_rdata;
        step();
        csr_rd = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [63:0] e, input string tag);
        logic [63:0] v;
        rd_val(a, v);
        check(v === e, tag, v, e);
    endtask

    task automatic wait_end(input string tag);
        logic [63:0] v;
        for (int k = 0; k < 100; k++) begin
            rd_val(8'h08, v);
            if (!v[12]) break;
        end
        check(!v[12], tag, v, 64'h0);
    endtask

    task automatic check_stream(input string tag);
        check(rx.size() == exp_w.size(), tag, 64'(rx.size()), 64'(exp_w.size()));
        for (int i = 0; i < exp_w.size() && i < rx.size(); i++)
            check(rx[i] == exp_w[i], tag, 64'(rx[i]), 64'(exp_w[i]));
        rx.delete();
        exp_w.delete();
    endtask

    initial begin
        logic [63:0] v;
        int sent, tries;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        step();

        // R1 reset values
        rd_check(8'h08, 64'h0, "R1 control after reset");
        rd_check(8'h10, 64'h0010_0008, "R1 status after reset");
        rd_check(8'h20, 64'h0, "R1 errors after reset");
        // R12 identity words and unmapped offset
        rd_check(8'h00, HDR, "R12 header");
        rd_check(8'hA8, IDL, "R12 id low");
        rd_check(8'hB0, IDH, "R12 id high");
        rd_check(8'h28, 64'h0, "R12 unmapped");

        // R6 data write while idle
        wr(8'h18, 64'h0000_0000_DEAD_BEEF);
        step();
        rd_check(8'h10, 64'h0010_0008, "R6 idle data write ignored");
        check(!snk_valid, "R6 sink idle", 64'(snk_valid), 64'h0);

        // R2 reset handshake
        wr(8'h08, 64'h1);
        rd_check(8'h08, 64'h11, "R2 ack set");
        rd_check(8'h10, 64'h0110_0008, "R2 host status reset");
        wr(8'h08, 64'h0);
        rd_check(8'h08, 64'h0, "R2 ack cleared");
        rd_check(8'h10, 64'h0010_0008, "R2 host status idle");

        // R3 start with region 2, kind 1
        wr(8'h08, 64'hA5A5_0001_0000_5200);
        rd_check(8'h08, 64'hA5A5_0001_0000_5200, "R3 start latched");
        rd_check(8'h10, 64'h0210_0008, "R3 host status load");
        check(region_sel == 2'd2 && image_kind && load_active, "R3 outputs",
              {61'h0, region_sel, image_kind}, 64'h5);

        // R4 three words, upper halves junk, sink stalled
        for (int i = 0; i < 3; i++) begin
            wr(8'h18, {32'hFFFF_FFFF, 32'h0000_1000 + 32'(i)});
            exp_w.push_back(32'h0000_1000 + 32'(i));
        end
        rd_check(8'h10, 64'h0240_0005, "R4 R11 credit after three");
        check(snk_data == 32'h0000_1000, "R7 head word", 64'(snk_data), 64'h1000);

        for (int i = 3; i < 8; i++) begin
            wr(8'h18, {32'h1234_5678, 32'h0000_1000 + 32'(i)});
            exp_w.push_back(32'h0000_1000 + 32'(i));
        end
        rd_check(8'h10, 64'h0260_0000, "R4 R11 zero credit full");
        // R5 write at zero credit
        wr(8'h18, 64'h0000_0000_0BAD_0BAD);
        rd_check(8'h20, 64'h10, "R5 overflow flagged");
        rd_check(8'h10, 64'h0261_0000, "R10 failed flag");

        // R3 second start with another region ignored
        wr(8'h08, 64'hA5A5_0001_0000_1100);
        rd_check(8'h08, 64'hA5A5_0001_0000_5200, "R3 restart ignored");

        // R9 strobes, reserved bit, W1C, set wins
        err_src = 7'b010_0010; step(); err_src = '0;
        rd_check(8'h20, 64'h12, "R9 strobe sets, bit5 never");
        wr(8'h20, 64'h10);
        rd_check(8'h20, 64'h02, "R9 w1c");
        err_src = 7'b000_0010; wr(8'h20, 64'h02); err_src = '0;
        rd_check(8'h20, 64'h02, "R9 set beats clear");
        wr(8'h20, 64'h7F);
        rd_check(8'h20, 64'h0, "R9 all cleared");
        rd_check(8'h10, 64'h0260_0000, "R10 failed flag clear");

        // R8 push complete while sink stalled
        wr(8'h08, 64'hA5A5_0001_0000_7200);
        rd_check(8'h10, 64'h0360_0000, "R8 host status drain");
        repeat (5) step();
        check(load_active, "R8 start held while words remain", 64'(load_active), 64'h1);
        snk_ready = 1'b1;
        wait_end("R8 start cleared after drain");
        rd_check(8'h08, 64'hA5A5_0001_0000_4200, "R8 control after end");
        rd_check(8'h10, 64'h0010_0008, "R8 status idle");
        check_stream("R7 order first load");

        // R2 reset in mid-load flushes queued words
        snk_ready = 1'b0;
        wr(8'h08, 64'h1000);
        wr(8'h18, 64'h77);
        wr(8'h18, 64'h78);
        wr(8'h08, 64'h1);
        rd_check(8'h10, 64'h0110_0008, "R2 flush on reset");
        check(!snk_valid && !load_active, "R2 sink empty after reset",
              {62'h0, snk_valid, load_active}, 64'h0);
        wr(8'h08, 64'h0);
        rx.delete();

        // R4 R7 credit-paced stream with ready toggling
        wr(8'h08, 64'h0000_0000_0000_1300);
        sent = 0; tries = 0;
        while (sent < 20 && tries < 500) begin
            tries++;
            snk_ready = (tries % 3) != 0;
            rd_val(8'h10, v);
            if (v[8:0] > 9'd1) begin
                wr(8'h18, {32'hCCCC_0000, 32'h1000_0000 + 32'(sent * 7)});
                exp_w.push_back(32'h1000_0000 + 32'(sent * 7));
                sent++;
            end
        end
        check(sent == 20, "R4 credit pacing", 64'(sent), 64'd20);
        wr(8'h08, 64'h0000_0000_0000_3300);
        snk_ready = 1'b1;
        wait_end("R8 second load ends");
        check_stream("R7 order streamed load");
        check(region_sel == 2'd3 && !image_kind, "R3 second region",
              {61'h0, region_sel, image_kind}, 64'h6);

        step();
        finish_run();
    end

endmodule